// File: doc/BRIEF.md
# Register-Programmed SPI Master with Phased Transfers

This block is an SPI master driven by a 32-bit word-addressed register bus. Software loads a command word of up to four bytes, fills up to eight 32-bit data words, programs one length register with separate bit counts for a command phase, a transmit phase and a receive phase, and then writes a launch bit. The block runs the three phases back to back on one serial clock: command bits first, then transmit data bits, then receive bits. The receive bits are written into the same data words that held the transmit bytes.

Clock polarity, clock phase, bit order and a serial clock divider come from a configuration register. The select lines are software-owned and independent of the transfer engine: a one-hot value written to the select register drives the matching active-low pin. The bus is half-duplex: the output line is held low while the receive phase runs. While a transfer is in flight, the busy flag reads 1 and the command, data, configuration and length registers are write-protected.

Top module: `spim_top`

## Requirements
- R1: After reset the busy flag is 0, every select pin is high, the serial clock and data output are 0, and the control (0x00), command (0x04), data (0x08..0x24), configuration (0x28), length (0x2C) and select (0x38) registers read 0.
- R2: While idle, the command, data and length registers read back the value written. The configuration register reads back the written value masked to its implemented bits 31:29, 27:16 and 5:2. The launch bit (control bit 8) always reads 0.
- R3: Writing 1 to control bit 8 while idle starts a transfer. Control bit 16 (busy) reads 1 from the next cycle until the transfer ends.
- R4: The serial output carries the command bits, then the transmit bits, then the receive phase. The length register holds the command count in bits 31:24 (clamped to 32), the receive count in bits 23:12 (clamped to 256) and the transmit count in bits 11:0 (clamped to 256). When sent MSB-first, the command is taken from bit count-1 down to bit 0, so a short command is right-aligned.
- R5: Data byte i occupies bits 8*(i mod 4)+7..8*(i mod 4) of data word i/4. With configuration bit 3 clear, each byte is sent bit 7 first. With bit 3 set, each data byte is sent bit 0 first, and the command is sent from bit 0 upward.
- R6: Receive bit j is stored at the same byte and bit position that transmit bit j would be taken from. Data bits beyond the receive count keep their earlier contents.
- R7: With divider field N (configuration bits 27:16), each bit lasts N+2 system clocks. Busy stays high for exactly (total bits)*(N+2)+1 cycles.
- R8: The serial clock idles at configuration bit 4 (polarity). With configuration bit 5 (phase) clear, the sampling edge is the one leaving the idle level. With it set, the sampling edge is the one returning to the idle level. The receive line is sampled at that edge.
- R9: A phase with a zero count is skipped. When all three counts are zero, busy is high for exactly one cycle and the serial clock does not move.
- R10: While busy, a launch write is ignored. Writes to the command, data, configuration and length registers are also ignored while busy.
- R11: Writing a value with exactly one bit k set to the select register drives select pin k low. Writing zero drives all select pins high. A value with more than one bit set is ignored.
- R12: The serial output changes only at bit boundaries and is 0 while idle and during the receive phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr while bus_sel is high |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low one-hot selects |

## Verification
Every cycle, the embedded properties check the following: the select register stays one-hot or empty, a finishing state always hands back to idle, an idle launch always leaves idle, the divider counter stays below the ratio, the serial output holds within a bit, and every sample point is followed by a serial clock edge. Other behaviour needs the bench scenarios. That covers the order and values of bits across the three phases under every clock mode and bit order, the clamping of oversized counts, the placement of received bits in the data words, the exact busy length, and the protection of registers against writes made during a transfer. A slave model in the bench supplies those observations.

// File: rtl/spim_pkg.sv
package spim_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CMD  = 3'd1,
      PH_TX   = 3'd2,
      PH_RX   = 3'd3,
      PH_FIN  = 3'd4
   } spim_phase_e;

   // word indices (byte address >> 2); software decodes these
   localparam logic [5:0] W_CTRL  = 6'h00;
   localparam logic [5:0] W_CMD   = 6'h01;
   localparam logic [5:0] W_DATA0 = 6'h02;
   localparam logic [5:0] W_CFG   = 6'h0A;
   localparam logic [5:0] W_LEN   = 6'h0B;
   localparam logic [5:0] W_CSEL  = 6'h0E;

   localparam int CTRL_GO_BIT   = 8;
   localparam int CTRL_BUSY_BIT = 16;

   localparam int CFG_LSB_BIT  = 3;
   localparam int CFG_CPOL_BIT = 4;
   localparam int CFG_CPHA_BIT = 5;
   localparam int CFG_DIV_LO   = 16;
   localparam int CFG_DIV_W    = 12;
   localparam logic [31:0] CFG_MASK = 32'hEFFF_003C;

   typedef struct packed {
      logic                 lsb_first;
      logic                 cpol;
      logic                 cpha;
      logic [CFG_DIV_W-1:0] div_n;
   } spim_cfg_t;

endpackage

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int NCS        = 8,
   parameter int DATA_WORDS = 8,
   localparam int DATA_BITS = DATA_WORDS * 32,
   localparam int DIW       = $clog2(DATA_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [7:0]           bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic                 busy,
   input  logic                 rx_we,
   input  logic [DIW-1:0]       rx_pos,
   input  logic                 rx_bit,
   output logic                 go,
   output logic [31:0]          cmd_q,
   output logic [DATA_BITS-1:0] data_flat,
   output logic [31:0]          cfg_q,
   output logic [31:0]          len_q,
   output logic [NCS-1:0]       csel_q
);

   logic       wr_en;
   logic       wr_idle;
   logic [5:0] widx;
   logic [31:0] csel_rd;

   assign wr_en   = bus_sel & bus_we;
   assign wr_idle = wr_en & ~busy;
   assign widx    = bus_addr[7:2];
   assign go      = wr_idle && (widx == W_CTRL) && bus_wdata[CTRL_GO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         cfg_q <= '0;
         len_q <= '0;
      end else if (wr_idle) begin
         if (widx == W_CMD) cmd_q <= bus_wdata;
         if (widx == W_CFG) cfg_q <= bus_wdata & CFG_MASK;
         if (widx == W_LEN) len_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         csel_q <= '0;
      else if (wr_en && (widx == W_CSEL) && $onehot0(bus_wdata))
         csel_q <= bus_wdata[NCS-1:0];
   end

   for (genvar k = 0; k < DATA_WORDS; k++) begin : g_word
      logic [31:0] word_q;
      logic        hit_bus;
      logic        hit_rx;
      assign hit_bus = wr_idle && (widx == W_DATA0 + 6'(k));
      assign hit_rx  = rx_we && ((rx_pos >> 5) == DIW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (hit_bus)
            word_q <= bus_wdata;
         else if (hit_rx)
            word_q[rx_pos[4:0]] <= rx_bit;
      end
      assign data_flat[32*k +: 32] = word_q;
   end

   if (NCS < 32) begin : g_csel_pad
      assign csel_rd = {{(32-NCS){1'b0}}, csel_q};
   end else begin : g_csel_full
      assign csel_rd = csel_q;
   end

   always_comb begin
      int didx;
      didx      = int'(widx) - int'(W_DATA0);
      bus_rdata = '0;
      if (bus_sel) begin
         if (widx == W_CTRL)      bus_rdata[CTRL_BUSY_BIT] = busy;
         else if (widx == W_CMD)  bus_rdata = cmd_q;
         else if (widx == W_CFG)  bus_rdata = cfg_q;
         else if (widx == W_LEN)  bus_rdata = len_q;
         else if (widx == W_CSEL) bus_rdata = csel_rd;
         else if (didx >= 0 && didx < DATA_WORDS)
            bus_rdata = data_flat[32*didx +: 32];
      end
   end

   // R11
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(csel_q));

   // R10
   cmd_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && widx == W_CMD) |=> $stable(cmd_q));

endmodule

// File: rtl/spim_sclkgen.sv
module spim_sclkgen #(
   parameter int DIV_W = 12,
   localparam int CW   = DIV_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_n,
   output logic             bit_end,
   output logic             sample_now,
   output logic             first_half
);

   logic [CW-1:0] ratio;
   logic [CW-1:0] half;
   logic [CW-1:0] cnt_q;

   assign ratio      = CW'(div_n) + CW'(2);
   assign half       = ratio >> 1;
   assign bit_end    = run && (cnt_q == ratio - CW'(1));
   assign sample_now = run && (cnt_q == half - CW'(1));
   assign first_half = cnt_q < half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || bit_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CW'(1);
   end

   // R7
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < ratio));

endmodule

// File: rtl/spim_engine.sv
module spim_engine
   import spim_pkg::*;
#(
   parameter int CMD_BITS  = 32,
   parameter int DATA_BITS = 256,
   localparam int CNT_W    = $clog2(DATA_BITS + 1),
   localparam int DIW      = $clog2(DATA_BITS),
   localparam int CIW      = $clog2(CMD_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go,
   input  spim_cfg_t            cfg,
   input  logic [CNT_W-1:0]     cmd_n,
   input  logic [CNT_W-1:0]     tx_n,
   input  logic [CNT_W-1:0]     rx_n,
   input  logic [CMD_BITS-1:0]  cmd_word,
   input  logic [DATA_BITS-1:0] data_flat,
   input  logic                 spi_miso,
   input  logic                 bit_end,
   input  logic                 sample_now,
   input  logic                 first_half,
   output logic                 run,
   output logic                 busy,
   output logic                 sclk,
   output logic                 mosi,
   output logic                 rx_we,
   output logic [DIW-1:0]       rx_pos,
   output logic                 rx_bit
);

   spim_phase_e      phase_q;
   spim_phase_e      nxt;
   logic [CNT_W-1:0] bidx_q;
   logic [CNT_W-1:0] cur_n;
   logic [CNT_W-1:0] cmd_pos;
   logic [2:0]       bsel;
   logic [DIW-1:0]   dpos;
   logic             last_bit;

   always_comb begin
      case (phase_q)
         PH_CMD:  cur_n = cmd_n;
         PH_TX:   cur_n = tx_n;
         PH_RX:   cur_n = rx_n;
         default: cur_n = '0;
      endcase
      last_bit = (bidx_q == cur_n - CNT_W'(1));
      nxt = PH_FIN;
      if (phase_q == PH_IDLE && cmd_n != '0)
         nxt = PH_CMD;
      else if ((phase_q == PH_IDLE || phase_q == PH_CMD) && tx_n != '0)
         nxt = PH_TX;
      else if (phase_q != PH_RX && rx_n != '0)
         nxt = PH_RX;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bidx_q  <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: if (go) begin
               phase_q <= nxt;
               bidx_q  <= '0;
            end
            PH_CMD, PH_TX, PH_RX: if (bit_end) begin
               if (last_bit) begin
                  phase_q <= nxt;
                  bidx_q  <= '0;
               end else begin
                  bidx_q <= bidx_q + CNT_W'(1);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign run  = (phase_q == PH_CMD) || (phase_q == PH_TX) || (phase_q == PH_RX);
   assign busy = (phase_q != PH_IDLE);

   assign cmd_pos = cfg.lsb_first ? bidx_q : (cmd_n - CNT_W'(1) - bidx_q);
   assign bsel    = cfg.lsb_first ? bidx_q[2:0] : ~bidx_q[2:0];
   assign dpos    = {bidx_q[DIW-1:3], bsel};

   always_comb begin
      case (phase_q)
         PH_CMD:  mosi = cmd_word[cmd_pos[CIW-1:0]];
         PH_TX:   mosi = data_flat[dpos];
         default: mosi = 1'b0;
      endcase
   end

   assign sclk   = run ? (cfg.cpol ^ (cfg.cpha ? first_half : ~first_half)) : cfg.cpol;
   assign rx_we  = (phase_q == PH_RX) && sample_now;
   assign rx_pos = dpos;
   assign rx_bit = spi_miso;

   // R9
   fin_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_FIN) |=> (phase_q == PH_IDLE));

   // R3
   go_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE && go) |=> busy);

   // R12
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !bit_end) |=> $stable(mosi));

   // R8
   sample_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && sample_now) |=> (sclk != $past(sclk)));

endmodule

// File: rtl/spim_top.sv
module spim_top
   import spim_pkg::*;
#(
   parameter int NCS        = 8,
   parameter int DATA_WORDS = 8,
   parameter int CMD_BYTES  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_sel,
   input  logic           bus_we,
   input  logic [7:0]     bus_addr,
   input  logic [31:0]    bus_wdata,
   output logic [31:0]    bus_rdata,
   output logic           spi_sclk,
   output logic           spi_mosi,
   input  logic           spi_miso,
   output logic [NCS-1:0] spi_cs_n
);

   localparam int DATA_BITS = DATA_WORDS * 32;
   localparam int CMD_BITS  = CMD_BYTES * 8;
   localparam int CNT_W     = $clog2(DATA_BITS + 1);
   localparam int DIW       = $clog2(DATA_BITS);

   initial begin
      assert (NCS >= 1 && NCS <= 32) else $error("NCS out of range");
      assert (DATA_WORDS >= 1 && DATA_WORDS <= 8) else $error("DATA_WORDS out of range");
      assert (CMD_BYTES >= 1 && CMD_BYTES <= 4) else $error("CMD_BYTES out of range");
   end

   logic                 go;
   logic                 busy;
   logic                 run;
   logic [31:0]          cmd_q;
   logic [31:0]          cfg_q;
   logic [31:0]          len_q;
   logic [DATA_BITS-1:0] data_flat;
   logic [NCS-1:0]       csel_q;
   logic                 rx_we;
   logic [DIW-1:0]       rx_pos;
   logic                 rx_bit;
   logic                 bit_end;
   logic                 sample_now;
   logic                 first_half;
   spim_cfg_t            cfg;
   logic [CNT_W-1:0]     cmd_n;
   logic [CNT_W-1:0]     tx_n;
   logic [CNT_W-1:0]     rx_n;

   assign cfg.lsb_first = cfg_q[CFG_LSB_BIT];
   assign cfg.cpol      = cfg_q[CFG_CPOL_BIT];
   assign cfg.cpha      = cfg_q[CFG_CPHA_BIT];
   assign cfg.div_n     = cfg_q[CFG_DIV_LO +: CFG_DIV_W];

   assign cmd_n = (len_q[31:24] > 8'(CMD_BITS))   ? CNT_W'(CMD_BITS)  : CNT_W'(len_q[31:24]);
   assign rx_n  = (len_q[23:12] > 12'(DATA_BITS)) ? CNT_W'(DATA_BITS) : CNT_W'(len_q[23:12]);
   assign tx_n  = (len_q[11:0]  > 12'(DATA_BITS)) ? CNT_W'(DATA_BITS) : CNT_W'(len_q[11:0]);

   spim_regs #(.NCS(NCS), .DATA_WORDS(DATA_WORDS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .rx_we(rx_we), .rx_pos(rx_pos), .rx_bit(rx_bit),
      .go(go), .cmd_q(cmd_q), .data_flat(data_flat),
      .cfg_q(cfg_q), .len_q(len_q), .csel_q(csel_q)
   );

   spim_sclkgen #(.DIV_W(CFG_DIV_W)) u_sclk (
      .clk(clk), .rst_n(rst_n), .run(run), .div_n(cfg.div_n),
      .bit_end(bit_end), .sample_now(sample_now), .first_half(first_half)
   );

   spim_engine #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_BITS)) u_eng (
      .clk(clk), .rst_n(rst_n), .go(go), .cfg(cfg),
      .cmd_n(cmd_n), .tx_n(tx_n), .rx_n(rx_n),
      .cmd_word(cmd_q[CMD_BITS-1:0]), .data_flat(data_flat),
      .spi_miso(spi_miso), .bit_end(bit_end), .sample_now(sample_now),
      .first_half(first_half), .run(run), .busy(busy),
      .sclk(spi_sclk), .mosi(spi_mosi),
      .rx_we(rx_we), .rx_pos(rx_pos), .rx_bit(rx_bit)
   );

   assign spi_cs_n = ~csel_q;

endmodule

// File: tb/sim_spim_top.sv
module sim_spim_top;

   localparam int NCS = 8;
   localparam logic [7:0] A_CTRL = 8'h00, A_CMD = 8'h04, A_DATA = 8'h08,
                          A_CFG = 8'h28, A_LEN = 8'h2C, A_CSEL = 8'h38;
   localparam int MAXB = 600;
   localparam int WDOG = 190000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_sel = 1'b0;
   logic           bus_we = 1'b0;
   logic [7:0]     bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic           spi_sclk;
   logic           spi_mosi;
   logic           spi_miso = 1'b0;
   logic [NCS-1:0] spi_cs_n;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   int edge_n = 0;
   logic prev_sclk = 1'b0;
   bit cur_cpol = 1'b0;
   bit cur_cpha = 1'b0;
   logic mosi_cap [MAXB];
   logic miso_src [MAXB];
   logic [255:0] tb_data = '0;

   spim_top #(.NCS(NCS)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WDOG) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WDOG);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   // slave model: record output at each sampling edge, then present next input bit
   always @(negedge clk) begin
      if (rst_n && spi_sclk !== prev_sclk) begin
         if ((!cur_cpha && spi_sclk != cur_cpol) || (cur_cpha && spi_sclk == cur_cpol)) begin
            if (edge_n < MAXB) mosi_cap[edge_n] = spi_mosi;
            edge_n = edge_n + 1;
            if (edge_n < MAXB) spi_miso = miso_src[edge_n];
         end
      end
      prev_sclk = spi_sclk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp = n_cmp + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic wait_idle(input int t0, output int busy_cyc);
      int guard;
      logic [31:0] v;
      guard = 0;
      rd(A_CTRL, v);
      while (v[16] && guard < 40000) begin
         @(negedge clk);
         rd(A_CTRL, v);
         guard++;
      end
      busy_cyc = cyc - t0;
   endtask

   task automatic launch_wait(output int busy_cyc);
      int t0;
      wr(A_CTRL, 32'h100);
      t0 = cyc;
      wait_idle(t0, busy_cyc);
   endtask

   function automatic int clampi(input int v, input int m);
      return (v > m) ? m : v;
   endfunction

   function automatic int dpos(input int j, input bit lsb);
      return (j / 8) * 8 + (lsb ? (j % 8) : (7 - (j % 8)));
   endfunction

   task automatic run_case(input string tag, input logic [31:0] cmd, input int cc,
                           input int tc, input int rc, input int n,
                           input bit pol, input bit pha, input bit lsb);
      int c, t, r, bc, mism, mz;
      logic [31:0] v;
      logic e;
      c = clampi(cc, 32); t = clampi(tc, 256); r = clampi(rc, 256);
      cur_cpol = pol; cur_cpha = pha;
      wr(A_CFG, (32'(n) << 16) | (32'(pha) << 5) | (32'(pol) << 4) | (32'(lsb) << 3) | 32'h4);
      wr(A_CMD, cmd);
      wr(A_LEN, (32'(cc) << 24) | (32'(rc) << 12) | 32'(tc));
      for (int k = 0; k < 8; k++) begin
         v = $urandom;
         tb_data[32*k +: 32] = v;
         wr(A_DATA + 8'(4*k), v);
      end
      for (int k = 0; k < MAXB; k++) miso_src[k] = 1'($urandom % 2);
      @(negedge clk);
      edge_n = 0;
      spi_miso = miso_src[0];
      launch_wait(bc);
      // R4 R7 R8: edge count and duration
      chk(edge_n == c + t + r, "R4", {tag, " sampling edges"}, 32'(edge_n), 32'(c + t + r));
      chk(bc == (c + t + r) * (n + 2) + 1, "R7", {tag, " busy cycles"}, 32'(bc),
          32'((c + t + r) * (n + 2) + 1));
      mism = 0; mz = 0;
      for (int j = 0; j < c + t + r && j < MAXB; j++) begin
         if (j < c)          e = lsb ? cmd[j] : cmd[c - 1 - j];
         else if (j < c + t) e = tb_data[dpos(j - c, lsb)];
         else                e = 1'b0;
         if (mosi_cap[j] !== e) begin
            if (j < c + t) mism++; else mz++;
         end
      end
      // R4 R5: serial output stream
      chk(mism == 0, "R5", {tag, " output bit mismatches"}, 32'(mism), 32'd0);
      // R12: output low during receive
      chk(mz == 0, "R12", {tag, " output during receive"}, 32'(mz), 32'd0);
      for (int j = 0; j < r; j++) tb_data[dpos(j, lsb)] = miso_src[c + t + j];
      // R6: received data placement
      for (int k = 0; k < 8; k++) begin
         rd(A_DATA + 8'(4*k), v);
         chk(v === tb_data[32*k +: 32], "R6", {tag, " data word"}, v, tb_data[32*k +: 32]);
      end
      // R8 R12: idle levels
      chk(spi_sclk === pol, "R8", {tag, " idle clock level"}, 32'(spi_sclk), 32'(pol));
      chk(spi_mosi === 1'b0, "R12", {tag, " idle output"}, 32'(spi_mosi), 32'd0);
   endtask

   initial begin
      logic [31:0] v;
      int bc, t0, e0;
      void'($urandom(32'd20240611));
      for (int k = 0; k < MAXB; k++) begin mosi_cap[k] = 1'b0; miso_src[k] = 1'b0; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(A_CTRL, v); chk(v == 0, "R1", "control after reset", v, 0);
      rd(A_CMD, v);  chk(v == 0, "R1", "command after reset", v, 0);
      rd(A_CFG, v);  chk(v == 0, "R1", "config after reset", v, 0);
      rd(A_LEN, v);  chk(v == 0, "R1", "length after reset", v, 0);
      rd(A_DATA, v); chk(v == 0, "R1", "data0 after reset", v, 0);
      rd(A_CSEL, v); chk(v == 0, "R1", "select after reset", v, 0);
      chk(spi_cs_n === '1, "R1", "select pins after reset", 32'(spi_cs_n), 32'hFF);
      chk(spi_sclk === 1'b0 && spi_mosi === 1'b0, "R1", "serial pins after reset",
          {30'd0, spi_sclk, spi_mosi}, 0);

      // R2: readback
      wr(A_CFG, 32'hFFFF_FFFF); rd(A_CFG, v);
      chk(v == 32'hEFFF_003C, "R2", "config mask", v, 32'hEFFF_003C);
      wr(A_CMD, 32'h1357_9BDF); rd(A_CMD, v);
      chk(v == 32'h1357_9BDF, "R2", "command readback", v, 32'h1357_9BDF);
      wr(A_DATA + 8'd12, 32'hCAFE_F00D); rd(A_DATA + 8'd12, v);
      chk(v == 32'hCAFE_F00D, "R2", "data3 readback", v, 32'hCAFE_F00D);
      wr(A_LEN, 32'h1234_5678); rd(A_LEN, v);
      chk(v == 32'h1234_5678, "R2", "length readback", v, 32'h1234_5678);
      wr(A_CFG, 32'h0); wr(A_LEN, 32'h0);

      // R9: all counts zero
      @(negedge clk); edge_n = 0; cur_cpol = 0; cur_cpha = 0;
      launch_wait(bc);
      chk(bc == 1, "R9", "busy for empty transfer", 32'(bc), 1);
      chk(edge_n == 0, "R9", "clock edges for empty transfer", 32'(edge_n), 0);
      rd(A_CTRL, v); chk(v[8] == 1'b0, "R2", "launch bit reads 0", v, 0);

      // R4 R5: directed modes
      run_case("mode0 short cmd", 32'hFFFF_12A5, 16, 16, 0, 0, 0, 0, 0);
      run_case("mode3 rx lsb", 32'h0, 0, 0, 24, 1, 1, 1, 1);
      run_case("mode1 all phases", 32'hDEAD_BEEF, 32, 40, 48, 2, 0, 1, 0);
      run_case("mode2 lsb cmd", 32'h0000_00C3, 8, 8, 8, 3, 1, 0, 1);
      // R4: clamped counts (40 -> 32, 300 -> 256)
      run_case("clamp", 32'hA5A5_0F0F, 40, 300, 0, 0, 0, 0, 0);
      // R7: largest divider
      run_case("max divider", 32'h0000_0081, 8, 0, 0, 4095, 0, 0, 0);

      // R10: writes while busy are ignored
      cur_cpol = 0; cur_cpha = 0;
      wr(A_CFG, 32'h0002_0000);
      wr(A_LEN, 32'h0000_0040);
      wr(A_DATA, 32'h1111_2222);
      @(negedge clk); edge_n = 0;
      wr(A_CTRL, 32'h100);
      t0 = cyc;
      wr(A_DATA, 32'hBAD0_BAD0);
      wr(A_LEN, 32'h0800_0008);
      wr(A_CFG, 32'h0000_0030);
      wr(A_CTRL, 32'h100);
      wait_idle(t0, bc);
      chk(bc == 64 * 4 + 1, "R10", "busy with writes during transfer", 32'(bc), 32'(64*4+1));
      rd(A_DATA, v); chk(v == 32'h1111_2222, "R10", "data0 protected", v, 32'h1111_2222);
      rd(A_LEN, v);  chk(v == 32'h0000_0040, "R10", "length protected", v, 32'h40);
      rd(A_CFG, v);  chk(v == 32'h0002_0000, "R10", "config protected", v, 32'h0002_0000);
      chk(edge_n == 64, "R10", "no relaunch", 32'(edge_n), 64);

      // R11: chip selects
      wr(A_CSEL, 32'h8);
      chk(spi_cs_n === 8'hF7, "R11", "select 3 asserted", 32'(spi_cs_n), 32'hF7);
      wr(A_CSEL, 32'h6);
      chk(spi_cs_n === 8'hF7, "R11", "multi-bit write ignored", 32'(spi_cs_n), 32'hF7);
      rd(A_CSEL, v); chk(v == 32'h8, "R11", "select readback", v, 32'h8);
      wr(A_CSEL, 32'h0);
      chk(spi_cs_n === 8'hFF, "R11", "select released", 32'(spi_cs_n), 32'hFF);

      // R3: busy visible after launch
      wr(A_CFG, 32'h0); wr(A_LEN, 32'h0800_0000);
      @(negedge clk); edge_n = 0; cur_cpol = 0; cur_cpha = 0;
      wr(A_CTRL, 32'h100);
      rd(A_CTRL, v); chk(v == 32'h0001_0000, "R3", "busy after launch", v, 32'h0001_0000);
      wait_idle(cyc, bc);
      e0 = edge_n;
      chk(e0 == 8, "R3", "launched transfer length", 32'(e0), 8);

      // random mix
      for (int i = 0; i < 16; i++) begin
         run_case("random", $urandom, 8 * int'($urandom % 5), 8 * int'($urandom % 33),
                  8 * int'($urandom % 33), int'($urandom % 5),
                  1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule